// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the execution core of a 32-bit integer datapath. Each cycle it takes two operands and a five-bit operation code. It produces, without any register on the path, a result word, a strobe saying whether that result should be written back, and the next value of a four-bit status word. The status word holds negative, zero, carry and signed overflow. It sits in a register inside the block and is loaded on a clock edge only when the caller raises the flag-update enable.

The with-carry arithmetic forms and the rotate-through-carry read the carry bit from that internal register. This lets a caller chain multi-word arithmetic with no external storage. The four compare and test codes compute flags like their arithmetic or logical counterparts but never ask for a write-back. There is no stream interface: nothing is buffered, so there is no back-pressure. The result simply follows the inputs in the same cycle.

Status bits are ordered {N, Z, C, V}, with N in bit 3 and V in bit 0. Shift codes take operand A as the value and bits [4:0] of operand B as the distance.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset the status word `flags` reads 4'b0000.
- R2: Code 0 (add) gives A+B and code 1 (add-with-carry) gives A+B+C. C is the unsigned carry out and V is signed overflow. For example, 0xFFFFFFFF+1 gives 0 with NZCV=0110, and 0x7FFFFFFF+1 gives 0x80000000 with NZCV=1001.
- R3: Code 2 (subtract) gives A-B and code 3 (subtract-with-carry) gives A-B-(1-C). C is set when no borrow occurs, and V is signed overflow.
- R4: Code 4 (reverse subtract) gives B-A and code 5 (its with-carry form) gives B-A-(1-C), with the same flag rules as R3.
- R5: Codes 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and A AND NOT B. N and Z follow the result, while C and V keep their current values.
- R6: Code 10 returns B and code 11 returns NOT B. N and Z follow the result, while C and V are kept.
- R7: Codes 12 (shift left logical), 13 (shift right logical), 14 (shift right arithmetic) and 15 (rotate right) move A by B[4:0] places, and C takes the last bit moved out. A distance of 0 returns A and keeps C. V is always kept.
- R8: Code 16 returns {C, A[31:1]} and sets C to A[0], keeping V.
- R9: Codes 17, 18, 19 and 20 compute the flags of subtract, add, AND and XOR respectively, and hold `result_we` low. All other codes from 0 to 16 raise `result_we`.
- R10: `flags` loads `flags_next` on a rising clock edge when `flag_we` is high, and holds otherwise.
- R11: Codes 21 to 31 are reserved. They drive `result` to 0, hold `result_we` low, and make `flags_next` equal `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | First operand; value for shifts |
| op_b | input | 32 | Second operand; B[4:0] is the shift distance |
| op_sel | input | 5 | Operation code |
| flag_we | input | 1 | Load the status register at the next edge |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result should be written back |
| flags_next | output | 4 | Status the current operation would produce, {N,Z,C,V} |
| flags | output | 4 | Registered status, {N,Z,C,V} |

## Verification
The clocked properties sample the operands and code only at rising edges. They therefore assume `op_a`, `op_b`, `op_sel` and `flag_we` are settled before each edge and are never X once reset is released. The stimulus meets this by changing every input at the falling edge and holding it for a full cycle. The stimulus also exercises the carry-reading codes only after earlier operations have loaded a known carry, so each expected value rests on flag history the bench has itself modelled.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_RSB = 5'd4,  OP_RSC = 5'd5,  OP_AND = 5'd6,  OP_ORR = 5'd7,
    OP_EOR = 5'd8,  OP_BIC = 5'd9,  OP_MOV = 5'd10, OP_MVN = 5'd11,
    OP_LSL = 5'd12, OP_LSR = 5'd13, OP_ASR = 5'd14, OP_ROR = 5'd15,
    OP_RRX = 5'd16, OP_CMP = 5'd17, OP_CMN = 5'd18, OP_TST = 5'd19,
    OP_TEQ = 5'd20
  } alu_op_e;

  localparam logic [4:0] OP_LAST = 5'd20;

  typedef enum logic [2:0] {
    SH_LSL, SH_LSR, SH_ASR, SH_ROR, SH_RRX
  } shift_kind_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[WIDTH-1:0];
    cout = wide[WIDTH];
    ovf  = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  shift_kind_e      kind,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  logic [WIDTH:0]   ext_l, ext_r, ext_a;
  logic [WIDTH-1:0] rot;

  always_comb begin
    ext_l = {1'b0, a} << amt;
    ext_r = {a, 1'b0} >> amt;
    ext_a = $signed({a, 1'b0}) >>> amt;
    rot   = (a >> amt) | (a << (WIDTH - int'(amt)));
    res   = a;
    cout  = cin;
    unique case (kind)
      SH_LSL: begin res = ext_l[WIDTH-1:0]; cout = ext_l[WIDTH]; end
      SH_LSR: begin res = ext_r[WIDTH:1];   cout = ext_r[0];     end
      SH_ASR: begin res = ext_a[WIDTH:1];   cout = ext_a[0];     end
      SH_ROR: begin res = rot;              cout = rot[WIDTH-1]; end
      SH_RRX: begin res = {cin, a[WIDTH-1:1]}; cout = a[0];      end
      default: ;
    endcase
    if (kind != SH_RRX && amt == '0) begin
      res  = a;
      cout = cin;
    end
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> q == '0);
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int OPW   = 5,
  localparam int SHW  = $clog2(WIDTH),
  localparam int NF   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [OPW-1:0]   op_sel,
  input  logic             flag_we,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [NF-1:0]    flags_next,
  output logic [NF-1:0]    flags
);
  logic [WIDTH-1:0] add_x, add_y, add_sum, sh_res, res;
  logic             add_cin, add_cout, add_ovf, sh_cout;
  logic             c_cur, v_cur, c_n, v_n, known;
  shift_kind_e      sh_kind;
  alu_op_e          op;

  assign op    = alu_op_e'(op_sel);
  assign c_cur = flags[FLAG_C];
  assign v_cur = flags[FLAG_V];

  // operand steering for the shared adder
  always_comb begin
    add_x   = op_a;
    add_y   = op_b;
    add_cin = 1'b0;
    case (op)
      OP_ADC:         add_cin = c_cur;
      OP_SUB, OP_CMP: begin add_y = ~op_b; add_cin = 1'b1; end
      OP_SBC:         begin add_y = ~op_b; add_cin = c_cur; end
      OP_RSB:         begin add_x = op_b; add_y = ~op_a; add_cin = 1'b1; end
      OP_RSC:         begin add_x = op_b; add_y = ~op_a; add_cin = c_cur; end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ASR:  sh_kind = SH_ASR;
      OP_ROR:  sh_kind = SH_ROR;
      OP_RRX:  sh_kind = SH_RRX;
      default: sh_kind = SH_LSL;
    endcase
  end

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .x(add_x), .y(add_y), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .a(op_a), .amt(op_b[SHW-1:0]), .kind(sh_kind), .cin(c_cur),
    .res(sh_res), .cout(sh_cout)
  );

  // result and flag selection
  always_comb begin
    res       = '0;
    result_we = 1'b1;
    c_n       = c_cur;
    v_n       = v_cur;
    known     = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC: begin
        res = add_sum; c_n = add_cout; v_n = add_ovf;
      end
      OP_CMP, OP_CMN: begin
        res = add_sum; c_n = add_cout; v_n = add_ovf; result_we = 1'b0;
      end
      OP_AND: res = op_a & op_b;
      OP_ORR: res = op_a | op_b;
      OP_EOR: res = op_a ^ op_b;
      OP_BIC: res = op_a & ~op_b;
      OP_MOV: res = op_b;
      OP_MVN: res = ~op_b;
      OP_TST: begin res = op_a & op_b; result_we = 1'b0; end
      OP_TEQ: begin res = op_a ^ op_b; result_we = 1'b0; end
      OP_LSL, OP_LSR, OP_ASR, OP_ROR, OP_RRX: begin
        res = sh_res; c_n = sh_cout;
      end
      default: begin known = 1'b0; result_we = 1'b0; end
    endcase
  end

  assign result     = known ? res : '0;
  assign flags_next = known ? {res[WIDTH-1], res == '0, c_n, v_n} : flags;

  alu_flag_reg #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flags_next), .q(flags)
  );

  p_add_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD && flags_next[FLAG_V]) |->
      (op_a[WIDTH-1] == op_b[WIDTH-1] && result[WIDTH-1] != op_a[WIDTH-1]));
  p_cmp_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |-> (!result_we && flags_next[FLAG_C] == (op_a >= op_b)));
  p_logic_keep_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= OP_AND && op_sel <= OP_BIC) |->
      flags_next[FLAG_C:FLAG_V] == flags[FLAG_C:FLAG_V]);
  p_zero_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= OP_LSL && op_sel <= OP_ROR && op_b[SHW-1:0] == '0) |->
      (result == op_a && flags_next[FLAG_C] == flags[FLAG_C]));
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_LAST) |-> (!result_we && result == '0 && flags_next == flags));
endmodule

// File: tb/sim_alu_flags_unit.sv
module sim_alu_flags_unit;
  typedef struct {
    logic [31:0] r;
    logic        we;
    logic [3:0]  nf;
    logic [3:0]  cur;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [4:0]  op_sel = 5'd10;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_next, flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mflags = 4'b0000;
  item_t q[$];
  event applied;

  always #5 clk = ~clk;

  alu_flags_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .result(result), .result_we(result_we),
    .flags_next(flags_next), .flags(flags)
  );

  function automatic item_t model(input logic [4:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [3:0] f);
    item_t it;
    logic [32:0] w;
    logic [31:0] r;
    logic c, v, ok, we;
    int n;
    c = f[1]; v = f[0]; ok = 1'b1; we = 1'b1; r = '0;
    n = int'(b[4:0]);
    case (op)
      0, 18: begin w = {1'b0,a} + {1'b0,b};            r = w[31:0]; c = w[32];
               v = (a[31] == b[31]) && (r[31] != a[31]); end
      1:     begin w = {1'b0,a} + {1'b0,b} + 33'(f[1]); r = w[31:0]; c = w[32];
               v = (a[31] == b[31]) && (r[31] != a[31]); end
      2, 17: begin r = a - b; c = (a >= b);
               v = (a[31] != b[31]) && (r[31] != a[31]); end
      3:     begin r = a - b - 32'(!f[1]); c = ({1'b0,a} >= ({1'b0,b} + 33'(!f[1])));
               v = (a[31] != b[31]) && (r[31] != a[31]); end
      4:     begin r = b - a; c = (b >= a);
               v = (a[31] != b[31]) && (r[31] != b[31]); end
      5:     begin r = b - a - 32'(!f[1]); c = ({1'b0,b} >= ({1'b0,a} + 33'(!f[1])));
               v = (a[31] != b[31]) && (r[31] != b[31]); end
      6, 19: r = a & b;
      7:     r = a | b;
      8, 20: r = a ^ b;
      9:     r = a & ~b;
      10:    r = b;
      11:    r = ~b;
      12: begin r = a; for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end end
      13: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end end
      14: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
      15: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[31:1]}; end end
      16: begin r = {f[1], a[31:1]}; c = a[0]; end
      default: ok = 1'b0;
    endcase
    if (op >= 17 && op <= 20) we = 1'b0;
    if (!ok) begin we = 1'b0; r = '0; end
    it.r = r;
    it.we = we;
    it.nf = ok ? {r[31], r == 32'd0, c, v} : f;
    it.cur = f;
    it.tag = "";
    return it;
  endfunction

  task automatic apply(input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic fwe, input string tag);
    item_t it;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; flag_we = fwe;
    it = model(op, a, b, mflags);
    it.tag = tag;
    q.push_back(it);
    -> applied;
    @(posedge clk);
    if (fwe) mflags = it.nf;
  endtask

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(applied);
      #2;
      if (q.size() != 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.r || result_we !== e.we || flags_next !== e.nf || flags !== e.cur) begin
          errors++;
          $display("FAIL %s: got r=%h we=%b nf=%b f=%b expected r=%h we=%b nf=%b f=%b",
                   e.tag, result, result_we, flags_next, flags, e.r, e.we, e.nf, e.cur);
        end
      end
    end
  end

  task automatic fixed(input string tag, input logic [31:0] er, input logic [3:0] enf);
    #3;
    checks++;
    if (result !== er || flags_next !== enf) begin
      errors++;
      $display("FAIL %s: got r=%h nf=%b expected r=%h nf=%b", tag, result, flags_next, er, enf);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    apply(5'd10, 32'h0, 32'h0, 1'b0, "R1 reset flags zero");
    // stated examples, also checked against fixed values
    apply(5'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, "R2 add -1+1");
    fixed("R2 add -1+1 fixed", 32'h0, 4'b0110);
    apply(5'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, "R2 add overflow");
    fixed("R2 add overflow fixed", 32'h8000_0000, 4'b1001);
    apply(5'd0, 32'hFFFF_FFFF, 32'd2, 1'b1, "R2 set carry");
    apply(5'd1, 32'd10, 32'd20, 1'b1, "R2 adc with C=1");
    apply(5'd1, 32'd10, 32'd20, 1'b1, "R2 adc with C=0");
    apply(5'd2, 32'd5, 32'd3, 1'b1, "R3 sub no borrow");
    apply(5'd2, 32'd3, 32'd5, 1'b1, "R3 sub borrow");
    apply(5'd3, 32'd9, 32'd4, 1'b1, "R3 sbc with C=0");
    apply(5'd3, 32'd9, 32'd4, 1'b1, "R3 sbc with C=1");
    apply(5'd2, 32'h8000_0000, 32'd1, 1'b1, "R3 sub overflow");
    apply(5'd4, 32'd3, 32'd10, 1'b1, "R4 rsb");
    apply(5'd5, 32'd10, 32'd3, 1'b1, "R4 rsc C=1");
    apply(5'd5, 32'd1, 32'd3, 1'b1, "R4 rsc C=0");
    apply(5'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, "R2 set C and V");
    apply(5'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, "R5 and keeps CV");
    apply(5'd7, 32'h0000_00F0, 32'h8000_000F, 1'b1, "R5 orr");
    apply(5'd8, 32'hAAAA_5555, 32'hAAAA_5555, 1'b1, "R5 eor zero");
    apply(5'd9, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, "R5 bic");
    apply(5'd10, 32'd0, 32'h1234_5678, 1'b1, "R6 mov");
    apply(5'd11, 32'd0, 32'h0000_0000, 1'b1, "R6 mvn");
    apply(5'd12, 32'h8000_0001, 32'd1, 1'b1, "R7 lsl 1");
    apply(5'd12, 32'h0000_0003, 32'd31, 1'b1, "R7 lsl 31");
    apply(5'd13, 32'h0000_0010, 32'd5, 1'b1, "R7 lsr 5");
    apply(5'd14, 32'h8000_0040, 32'd4, 1'b1, "R7 asr 4");
    apply(5'd15, 32'h0000_0001, 32'd1, 1'b1, "R7 ror 1");
    apply(5'd13, 32'hDEAD_BEEF, 32'h0000_0100, 1'b1, "R7 zero distance keeps C");
    apply(5'd16, 32'h0000_0003, 32'd0, 1'b1, "R8 rrx");
    apply(5'd16, 32'h0000_0002, 32'd0, 1'b1, "R8 rrx C in");
    apply(5'd17, 32'd7, 32'd7, 1'b1, "R9 cmp equal");
    apply(5'd17, 32'd2, 32'd9, 1'b1, "R9 cmp less");
    apply(5'd18, 32'hFFFF_FFFF, 32'd1, 1'b1, "R9 cmn");
    apply(5'd19, 32'h0F00_0000, 32'hF000_0000, 1'b1, "R9 tst");
    apply(5'd20, 32'h8000_0000, 32'h0, 1'b1, "R9 teq");
    apply(5'd2, 32'd1, 32'd2, 1'b0, "R10 no update");
    apply(5'd10, 32'd0, 32'd0, 1'b0, "R10 flags held");
    apply(5'd25, 32'h1111_1111, 32'h2222_2222, 1'b1, "R11 reserved");
    apply(5'd31, 32'hFFFF_FFFF, 32'h1, 1'b1, "R11 reserved top");
    apply(5'd10, 32'd0, 32'd5, 1'b0, "R11 flags after reserved");
    @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d left expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule